// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block collects every reason a small microcontroller may need to restart and turns them into two stretched reset outputs. One resets the peripherals and is held for a short count. The other resets the processor core and is held for a much longer count, which gives the oscillator time to settle. The requests come from six places: power-on, a debounced pattern on an input port, a watchdog timeout, oscillator loss, sleep entry and a sleep counter. Power-on is the block's own asynchronous active-low reset. The other five arrive as single-bit requests and each passes through a two-flop synchronizer.

A third output, `opt_rst_n`, follows power-on only. It clears the option registers and the sleep-enable bit in the rest of the chip. Those same registers inside this block are also cleared by power-on alone, so watchdog, oscillator, pin and sleep resets leave them unchanged. A four-word register window holds the port pattern (a care mask and a level word), the per-source inhibits, the sleep enable and a write-one-to-clear record of the reset causes.

A free-running divider supplies three clock-enable taps: one for the debouncer, one for the system stretch and one for the CPU stretch. Each stretch counts its own taps after the last request has gone away. A request that arrives during a stretch starts the count again from zero.

Top module: `reset_hub`

## Requirements
- R1: While `por_n` is low, `sys_rst_n`, `cpu_rst_n` and `opt_rst_n` are all low. `opt_rst_n` rises on the second clock edge after `por_n` is released. After power-on the status register (address 3) reads 0x01, with only bit 0, the power-on cause, set.
- R2: Each enabled source request pulls `sys_rst_n` and `cpu_rst_n` low on the third clock edge after the request input rises: two synchronizer stages, then the stretch register.
- R3: After the last request is removed, `sys_rst_n` stays low until SYS_TICKS enables of the divider tap at stage SYS_TAP have been counted. One such enable occurs every 2^SYS_TAP clocks. The count starts with the third edge after the request input falls.
- R4: `cpu_rst_n` is released the same way, counting CPU_TICKS enables of stage CPU_TAP. `cpu_rst_n` is never high while `sys_rst_n` is low.
- R5: A request that arrives while a stretch is running restarts both stretch counts from zero.
- R6: Only power-on clears the mask, level and control registers, including the sleep-enable bit. Resets from any other source leave their contents unchanged.
- R7: The port matches when the mask is nonzero and every pin whose mask bit is 1 equals the corresponding level bit. The synchronized match is sampled on each enable of stage DEB_TAP. A pin reset is requested only after two consecutive samples both show a match.
- R8: Control register (address 2) bits: bit 0 inhibits the pin source, bit 1 the watchdog, bit 2 the oscillator source and bit 3 sleep entry. An inhibited source causes no reset and sets no status bit. The sleep-counter source has no inhibit.
- R9: A sleep request causes a reset only while control bit 4 (sleep enable) is 1 and bit 3 is 0.
- R10: Status bits: 0 power-on, 1 pin, 2 watchdog, 3 oscillator, 4 sleep, 5 sleep counter. A bit is set on every cycle its enabled source is active. Writing 1 to a bit clears it, except when that source is still active: setting wins over clearing. Writing 0 leaves the bit unchanged.
- R11: Address 0 is the care mask and address 1 the level word, each PORT_W bits wide. Address 2 is the 5-bit control register. Reads return the written value with the unused upper bits as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| port_pins | input | PORT_W | Asynchronous port pins compared with the pattern |
| wdog_req | input | 1 | Watchdog timeout request |
| osc_fail_req | input | 1 | Oscillator loss request |
| sleep_req | input | 1 | Sleep entry request |
| slpcnt_req | input | 1 | Sleep counter request |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| sys_rst_n | output | 1 | Stretched system reset, active low |
| cpu_rst_n | output | 1 | Stretched CPU reset, active low |
| opt_rst_n | output | 1 | Power-on-only reset for option state, active low |

## Verification
The bench builds the block with a 4-pin port and divider taps at stages 1, 2 and 4, with three ticks for each stretch. At that size a debounce sample comes every 2 clocks, a system release within 14 clocks and a CPU release within 50 clocks. This makes it practical to sweep all 16 pin values under several mask and level pairs. The same setting covers every source in both its inhibited and enabled state, the three sleep-gate combinations and restarts in mid-stretch. Release times are checked against windows computed from the tap periods.

// File: rtl/reset_hub_pkg.sv
package reset_hub_pkg;
  localparam int BUS_W = 8;
  localparam int SRC_N = 6;

  localparam int SRC_POR    = 0;
  localparam int SRC_PIN    = 1;
  localparam int SRC_WDOG   = 2;
  localparam int SRC_OSC    = 3;
  localparam int SRC_SLEEP  = 4;
  localparam int SRC_SLPCNT = 5;

  localparam logic [1:0] ADDR_MASK  = 2'd0;
  localparam logic [1:0] ADDR_LEVEL = 2'd1;
  localparam logic [1:0] ADDR_CTRL  = 2'd2;
  localparam logic [1:0] ADDR_STAT  = 2'd3;

  typedef struct packed {
    logic sleep_en;
    logic sleep_inh;
    logic osc_inh;
    logic wdog_inh;
    logic pin_inh;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/reset_hub_sync.sv
module reset_hub_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/reset_hub_divider.sv
module reset_hub_divider #(
  parameter int DEB_TAP = 10,
  parameter int SYS_TAP = 11,
  parameter int CPU_TAP = 18
) (
  input  logic clk,
  input  logic por_n,
  output logic deb_tick,
  output logic sys_tick,
  output logic cpu_tick
);
  localparam int DIV_W = CPU_TAP;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign deb_tick = &cnt_q[DEB_TAP-1:0];
  assign sys_tick = &cnt_q[SYS_TAP-1:0];
  assign cpu_tick = &cnt_q[CPU_TAP-1:0];
endmodule

// File: rtl/reset_hub_debounce.sv
module reset_hub_debounce #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              tick,
  input  logic [PORT_W-1:0] pins,
  input  logic [PORT_W-1:0] care,
  input  logic [PORT_W-1:0] level,
  output logic              match_o,
  output logic              req_o
);
  logic       match_c;
  logic [1:0] smp_q, smp_d;
  logic       req_q, req_d;

  always_comb begin
    match_c = (|care) && (((pins ^ level) & care) == '0);
  end

  always_comb begin
    smp_d = smp_q;
    req_d = req_q;
    if (tick) begin
      smp_d = {smp_q[0], match_c};
      req_d = smp_q[0] & match_c;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      smp_q <= '0;
      req_q <= 1'b0;
    end else begin
      smp_q <= smp_d;
      req_q <= req_d;
    end
  end

  assign match_o = match_c;
  assign req_o   = req_q;
endmodule

// File: rtl/reset_hub_stretch.sv
module reset_hub_stretch #(
  parameter int TICKS = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic trigger,
  input  logic tick,
  output logic rst_n_o
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic          active_q, active_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    if (trigger) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (active_q && tick) begin
      if (cnt_q == LAST) begin
        active_d = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  assign rst_n_o = ~active_q;
endmodule

// File: rtl/reset_hub.sv
module reset_hub
  import reset_hub_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int DEB_TAP   = 10,
  parameter int SYS_TAP   = 11,
  parameter int CPU_TAP   = 18,
  parameter int SYS_TICKS = 4,
  parameter int CPU_TICKS = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [PORT_W-1:0] port_pins,
  input  logic              wdog_req,
  input  logic              osc_fail_req,
  input  logic              sleep_req,
  input  logic              slpcnt_req,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              sys_rst_n,
  output logic              cpu_rst_n,
  output logic              opt_rst_n
);
  localparam int REQ_N = 4;

  // option and status registers: power-on domain only
  logic [PORT_W-1:0] mask_q, mask_d;
  logic [PORT_W-1:0] level_q, level_d;
  ctrl_t             ctrl_q, ctrl_d;
  logic [SRC_N-1:0]  stat_q, stat_d;

  logic [REQ_N-1:0]  req_s;
  logic [PORT_W-1:0] pins_s;
  logic              deb_tick, sys_tick, cpu_tick;
  logic              pin_match_s, pin_req;
  logic [SRC_N-1:0]  src_vec;
  logic              any_src;
  logic [SRC_N-1:0]  stat_clr;

  reset_hub_sync #(.W(REQ_N)) u_req_sync (
    .clk   (clk),
    .por_n (por_n),
    .d     ({slpcnt_req, sleep_req, osc_fail_req, wdog_req}),
    .q     (req_s)
  );

  reset_hub_sync #(.W(PORT_W)) u_pin_sync (
    .clk   (clk),
    .por_n (por_n),
    .d     (port_pins),
    .q     (pins_s)
  );

  reset_hub_sync #(.W(1)) u_opt_sync (
    .clk   (clk),
    .por_n (por_n),
    .d     (1'b1),
    .q     (opt_rst_n)
  );

  reset_hub_divider #(
    .DEB_TAP (DEB_TAP),
    .SYS_TAP (SYS_TAP),
    .CPU_TAP (CPU_TAP)
  ) u_div (
    .clk      (clk),
    .por_n    (por_n),
    .deb_tick (deb_tick),
    .sys_tick (sys_tick),
    .cpu_tick (cpu_tick)
  );

  reset_hub_debounce #(.PORT_W(PORT_W)) u_deb (
    .clk     (clk),
    .por_n   (por_n),
    .tick    (deb_tick),
    .pins    (pins_s),
    .care    (mask_q),
    .level   (level_q),
    .match_o (pin_match_s),
    .req_o   (pin_req)
  );

  // source gating
  always_comb begin
    src_vec             = '0;
    src_vec[SRC_PIN]    = pin_req & ~ctrl_q.pin_inh;
    src_vec[SRC_WDOG]   = req_s[0] & ~ctrl_q.wdog_inh;
    src_vec[SRC_OSC]    = req_s[1] & ~ctrl_q.osc_inh;
    src_vec[SRC_SLEEP]  = req_s[2] & ctrl_q.sleep_en & ~ctrl_q.sleep_inh;
    src_vec[SRC_SLPCNT] = req_s[3];
    any_src             = |src_vec;
  end

  // two stretch domains built from one template
  for (genvar g = 0; g < 2; g++) begin : g_stretch
    localparam int TK = (g == 0) ? SYS_TICKS : CPU_TICKS;
    logic tick_sel;
    logic rst_n_w;
    assign tick_sel = (g == 0) ? sys_tick : cpu_tick;
    reset_hub_stretch #(.TICKS(TK)) u_str (
      .clk     (clk),
      .por_n   (por_n),
      .trigger (any_src),
      .tick    (tick_sel),
      .rst_n_o (rst_n_w)
    );
  end

  assign sys_rst_n = g_stretch[0].rst_n_w;
  assign cpu_rst_n = g_stretch[1].rst_n_w;

  // register next state
  always_comb begin
    mask_d   = mask_q;
    level_d  = level_q;
    ctrl_d   = ctrl_q;
    stat_clr = '0;
    if (bus_wr) begin
      case (bus_addr)
        ADDR_MASK:  mask_d   = bus_wdata[PORT_W-1:0];
        ADDR_LEVEL: level_d  = bus_wdata[PORT_W-1:0];
        ADDR_CTRL:  ctrl_d   = ctrl_t'(bus_wdata[CTRL_W-1:0]);
        default:    stat_clr = bus_wdata[SRC_N-1:0];
      endcase
    end
    stat_d = (stat_q & ~stat_clr) | src_vec;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mask_q  <= '0;
      level_q <= '0;
      ctrl_q  <= '0;
      stat_q  <= SRC_N'(1) << SRC_POR;
    end else begin
      mask_q  <= mask_d;
      level_q <= level_d;
      ctrl_q  <= ctrl_d;
      stat_q  <= stat_d;
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_MASK:  bus_rdata = BUS_W'(mask_q);
      ADDR_LEVEL: bus_rdata = BUS_W'(level_q);
      ADDR_CTRL:  bus_rdata = BUS_W'(ctrl_q);
      default:    bus_rdata = BUS_W'(stat_q);
    endcase
  end
endmodule

// File: rtl/reset_hub_chk.sv
module reset_hub_chk
  import reset_hub_pkg::*;
(
  input logic             clk,
  input logic             por_n,
  input logic             sys_rst_n,
  input logic             cpu_rst_n,
  input logic             opt_rst_n,
  input logic             any_src,
  input logic             sys_tick,
  input logic             cpu_tick,
  input logic             deb_tick,
  input logic             pin_match_s,
  input logic             pin_req,
  input logic [SRC_N-1:0] stat_q,
  input logic [SRC_N-1:0] src_vec,
  input ctrl_t            ctrl_q,
  input logic             bus_wr,
  input logic [1:0]       bus_addr
);
  assert_src_asserts_R2: assert property (@(posedge clk) disable iff (!por_n)
    any_src |=> (!sys_rst_n && !cpu_rst_n));

  assert_sys_on_tick_R3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst_n) |-> $past(sys_tick));

  assert_cpu_on_tick_R4: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cpu_rst_n) |-> $past(cpu_tick));

  assert_cpu_covers_sys_R4: assert property (@(posedge clk) disable iff (!por_n)
    !sys_rst_n |-> !cpu_rst_n);

  assert_ctrl_kept_R6: assert property (@(posedge clk) disable iff (!por_n)
    !(bus_wr && bus_addr == ADDR_CTRL) |=> $stable(ctrl_q));

  assert_opt_por_only_R1: assert property (@(posedge clk) disable iff (!por_n)
    !$fell(opt_rst_n));

  assert_pin_debounced_R7: assert property (@(posedge clk) disable iff (!por_n)
    $rose(pin_req) |-> $past(deb_tick && pin_match_s));

  assert_wdog_flag_cause_R10: assert property (@(posedge clk) disable iff (!por_n)
    $rose(stat_q[SRC_WDOG]) |-> $past(src_vec[SRC_WDOG]));

  assert_inhibit_wdog_R8: assert property (@(posedge clk) disable iff (!por_n)
    ctrl_q.wdog_inh |-> !src_vec[SRC_WDOG]);
endmodule

bind reset_hub reset_hub_chk u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .sys_rst_n   (sys_rst_n),
  .cpu_rst_n   (cpu_rst_n),
  .opt_rst_n   (opt_rst_n),
  .any_src     (any_src),
  .sys_tick    (sys_tick),
  .cpu_tick    (cpu_tick),
  .deb_tick    (deb_tick),
  .pin_match_s (pin_match_s),
  .pin_req     (pin_req),
  .stat_q      (stat_q),
  .src_vec     (src_vec),
  .ctrl_q      (ctrl_q),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr)
);

// File: tb/reset_hub_test.sv
`timescale 1ns/1ps
module reset_hub_test;
  localparam int PW = 4;
  localparam int ST = 2, CT = 4, STK = 3, CTK = 3;
  localparam int SP = 1 << ST, CP = 1 << CT;

  logic          clk = 1'b0;
  logic          por_n;
  logic [PW-1:0] port_pins;
  logic          wdog_req, osc_fail_req, sleep_req, slpcnt_req;
  logic          bus_wr;
  logic [1:0]    bus_addr;
  logic [7:0]    bus_wdata, bus_rdata;
  logic          sys_rst_n, cpu_rst_n, opt_rst_n;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  reset_hub #(
    .PORT_W(PW), .DEB_TAP(1), .SYS_TAP(ST), .CPU_TAP(CT),
    .SYS_TICKS(STK), .CPU_TICKS(CTK)
  ) uut (
    .clk(clk), .por_n(por_n), .port_pins(port_pins),
    .wdog_req(wdog_req), .osc_fail_req(osc_fail_req),
    .sleep_req(sleep_req), .slpcnt_req(slpcnt_req),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sys_rst_n(sys_rst_n),
    .cpu_rst_n(cpu_rst_n), .opt_rst_n(opt_rst_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step(1);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 300 && !(sys_rst_n && cpu_rst_n); i++) step(1);
  endtask

  task automatic set_src(input int idx, input logic v);
    case (idx)
      2: wdog_req = v;
      3: osc_fail_req = v;
      4: sleep_req = v;
      default: slpcnt_req = v;
    endcase
  endtask

  // drop source at a negedge, then measure release times
  task automatic measure(input int idx, input string tag);
    int cs, cc;
    cs = 0; cc = 0;
    set_src(idx, 1'b0);
    for (int c = 1; c <= 120 && cc == 0; c++) begin
      step(1);
      if (sys_rst_n && cs == 0) cs = c;
      if (cpu_rst_n && cc == 0) cc = c;
    end
    check(cs >= 3 + (STK-1)*SP && cs <= 2 + STK*SP, {tag, " R3 sys release window"}, cs, 2 + STK*SP);
    check(cc >= 3 + (CTK-1)*CP && cc <= 2 + CTK*CP, {tag, " R4 cpu release window"}, cc, 2 + CTK*CP);
    check(cc > cs, {tag, " R4 cpu after sys"}, cc, cs);
  endtask

  task automatic run_src(input int idx, input bit expect_rst, input string tag);
    logic [7:0] s;
    set_src(idx, 1'b1);
    step(2);
    check(sys_rst_n == 1'b1, {tag, " R2 not yet asserted at edge 2"}, sys_rst_n, 1);
    step(1);
    check(sys_rst_n == !expect_rst, {tag, " R2/R8/R9 sys_rst_n"}, sys_rst_n, !expect_rst);
    check(cpu_rst_n == !expect_rst, {tag, " R2/R8/R9 cpu_rst_n"}, cpu_rst_n, !expect_rst);
    step(6);
    check(sys_rst_n == !expect_rst, {tag, " R8 held"}, sys_rst_n, !expect_rst);
    rd(2'd3, s);
    check(s[idx] == expect_rst, {tag, " R10 status cause bit"}, s[idx], expect_rst);
    if (expect_rst) measure(idx, tag);
    else set_src(idx, 1'b0);
    wait_idle();
    wr(2'd3, 8'h3F);
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] lv, mk;
    bit exp_m;
    int t0;
    por_n = 1'b0; port_pins = '0; wdog_req = 0; osc_fail_req = 0;
    sleep_req = 0; slpcnt_req = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    step(3);
    check({sys_rst_n, cpu_rst_n, opt_rst_n} == 3'b000, "R1 outputs low in power-on", {sys_rst_n, cpu_rst_n, opt_rst_n}, 0);
    por_n = 1'b1;
    step(1);
    check(opt_rst_n == 1'b0, "R1 opt still low at edge 1", opt_rst_n, 0);
    step(1);
    check(opt_rst_n == 1'b1, "R1 opt released at edge 2", opt_rst_n, 1);
    rd(2'd3, d);
    check(d == 8'h01, "R1 status after power-on", d, 1);
    wait_idle();
    check(sys_rst_n && cpu_rst_n, "R1 power-on stretch ends", {sys_rst_n, cpu_rst_n}, 3);

    // R11 register readback with upper bits zero
    wr(2'd0, 8'hFF); rd(2'd0, d); check(d == 8'h0F, "R11 mask readback", d, 8'h0F);
    wr(2'd1, 8'hA5); rd(2'd1, d); check(d == 8'h05, "R11 level readback", d, 8'h05);
    wr(2'd2, 8'hFF); rd(2'd2, d); check(d == 8'h1F, "R11 ctrl readback", d, 8'h1F);
    wr(2'd0, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h3F);
    rd(2'd3, d); check(d == 8'h00, "R10 status cleared by ones", d, 0);

    // R8 inhibits and sources; R3/R4 release windows
    wr(2'd2, 8'h02); run_src(2, 1'b0, "wdog inhibited");
    wr(2'd2, 8'h00); run_src(2, 1'b1, "wdog");
    wr(2'd2, 8'h04); run_src(3, 1'b0, "osc inhibited");
    wr(2'd2, 8'h00); run_src(3, 1'b1, "osc");
    wr(2'd2, 8'h07); run_src(5, 1'b1, "sleep counter no inhibit");
    // R9 sleep gate
    wr(2'd2, 8'h00); run_src(4, 1'b0, "sleep disabled");
    wr(2'd2, 8'h18); run_src(4, 1'b0, "sleep inhibited");
    wr(2'd2, 8'h10); run_src(4, 1'b1, "sleep enabled");

    // R5 restart during stretch
    wr(2'd2, 8'h00);
    wdog_req = 1'b1; step(5); wdog_req = 1'b0;
    step(6);
    check(sys_rst_n == 1'b0, "R5 still in stretch", sys_rst_n, 0);
    osc_fail_req = 1'b1; step(3);
    t0 = 0;
    osc_fail_req = 1'b0;
    for (int c = 1; c <= 60 && t0 == 0; c++) begin
      step(1);
      if (sys_rst_n) t0 = c;
    end
    check(t0 >= 3 + (STK-1)*SP && t0 <= 2 + STK*SP, "R5 sys count restarted", t0, 2 + STK*SP);
    wait_idle(); wr(2'd3, 8'h3F);

    // R10 set wins over clear, zero write keeps bit
    wdog_req = 1'b1; step(4);
    wr(2'd3, 8'h04); rd(2'd3, d);
    check(d[2] == 1'b1, "R10 set wins over clear", d[2], 1);
    wdog_req = 1'b0; wait_idle();
    wr(2'd3, 8'h00); rd(2'd3, d);
    check(d[2] == 1'b1, "R10 zero write keeps bit", d[2], 1);
    wr(2'd3, 8'h04); rd(2'd3, d);
    check(d[2] == 1'b0, "R10 one write clears bit", d[2], 0);

    // R7 pin pattern sweep
    for (int pr = 0; pr < 3; pr++) begin
      mk = (pr == 0) ? 8'h0F : (pr == 1) ? 8'h06 : 8'h00;
      lv = (pr == 0) ? 8'h0A : (pr == 1) ? 8'h02 : 8'h00;
      for (int p = 0; p < 16; p++) begin
        exp_m = (mk != 0) && ((((p[7:0]) ^ lv) & mk) == 0);
        wr(2'd0, 8'h00);
        port_pins = p[PW-1:0];
        wr(2'd1, lv); wr(2'd0, mk);
        step(12);
        check(sys_rst_n == !exp_m, $sformatf("R7 pin match mask=%0h lvl=%0h pins=%0h", mk, lv, p), sys_rst_n, !exp_m);
        wr(2'd0, 8'h00);
        wait_idle();
        rd(2'd3, d);
        check(d[1] == exp_m, "R10 pin cause bit", d[1], exp_m);
        wr(2'd3, 8'h3F);
      end
    end
    // R7 short glitch ignored
    port_pins = 4'h0; wr(2'd1, 8'h03); wr(2'd0, 8'h03);
    port_pins = 4'h3; step(2); port_pins = 4'h0;
    step(12);
    check(sys_rst_n == 1'b1, "R7 one-sample glitch ignored", sys_rst_n, 1);
    // R8 pin inhibit
    wr(2'd2, 8'h01); port_pins = 4'h3; step(12);
    check(sys_rst_n == 1'b1, "R8 pin inhibited", sys_rst_n, 1);
    rd(2'd3, d); check(d[1] == 1'b0, "R8 pin inhibited no flag", d[1], 0);
    port_pins = 4'h0; wr(2'd0, 8'h00);

    // R6 option registers survive other resets, cleared by power-on
    wr(2'd0, 8'h05); wr(2'd1, 8'h04); wr(2'd2, 8'h10);
    wdog_req = 1'b1; step(5); wdog_req = 1'b0; wait_idle();
    rd(2'd0, d); check(d == 8'h05, "R6 mask kept", d, 5);
    rd(2'd1, d); check(d == 8'h04, "R6 level kept", d, 4);
    rd(2'd2, d); check(d == 8'h10, "R6 sleep enable kept", d, 16);
    por_n = 1'b0; step(2);
    check(opt_rst_n == 1'b0, "R1 opt asserted on power-on", opt_rst_n, 0);
    por_n = 1'b1; step(2);
    rd(2'd0, d); check(d == 8'h00, "R6 mask cleared by power-on", d, 0);
    rd(2'd2, d); check(d == 8'h00, "R6 ctrl cleared by power-on", d, 0);
    rd(2'd3, d); check(d == 8'h01, "R1 status only power-on", d, 1);
    wait_idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule